// File: doc/BRIEF.md
# CAN Receive Filter Match Index Resolver

This block sits behind the acceptance-filter comparators of a CAN receiver. The comparators produce one hit bit per filter slot, four slots per filter bank. The resolver holds a small configuration word per bank: comparison width, list or mask mode, enable, and which of the two receive FIFOs the bank feeds. From these it decides whether a received frame goes to FIFO 0, to FIFO 1 or is dropped. It also computes the filter match index that is stored alongside the frame, so software can dispatch on it without decoding the identifier.

Index numbering depends only on the present configuration. Within each FIFO the filters are counted from zero in increasing bank order, and within a bank in slot order. Disabled banks still take their index values. The numbering is recomputed combinationally from the configuration registers, so a configuration write is reflected in the next frame. When several filters of the chosen FIFO hit, the winner is picked by width first, then by mode, then by lowest index. The answer is presented as a registered one-cycle strobe.

Top module: `can_flt_resolver`

## Requirements
- R1: After reset every bank is disabled, assigned to FIFO 0 and in 16-bit mask mode. The result strobe is low, the destination reads 2'b10 and the index reads 0. A frame with every hit bit set is then dropped.
- R2: `res_valid_o` is high in the cycle after each cycle with `frame_valid_i` high, and low otherwise. Back-to-back frames give back-to-back strobes.
- R3: Destination codes are 2'b00 for FIFO 0, 2'b01 for FIFO 1 and 2'b10 for drop. A frame that hits an enabled FIFO 0 filter goes to FIFO 0 even when a FIFO 1 filter also hits.
- R4: A frame with no enabled FIFO 0 hit goes to FIFO 1 if an enabled FIFO 1 filter hits. Otherwise it is dropped.
- R5: Hit bits of disabled banks are ignored. Hit bits on slots at or above the bank's filter count are also ignored.
- R6: Hit vector bit 4*b+s is slot s of bank b. A bank holds 1 filter in 32-bit mask mode, 2 in 32-bit list mode, 2 in 16-bit mask mode and 4 in 16-bit list mode. These use slots 0 up to count-1. Indices are numbered per FIFO from 0, in ascending bank order and then in ascending slot order, and disabled banks are counted too.
- R7: Among hits in the chosen FIFO, 32-bit filters win over 16-bit filters. At equal width, list mode wins over mask mode. At equal width and mode, the lowest index wins.
- R8: A write with `cfg_we_i` high stores `cfg_data_i` into bank `cfg_bank_i`. The bits are: bit 0 = 32-bit width, bit 1 = list mode, bit 2 = enabled, bit 3 = FIFO 1. A frame in the same cycle as the write uses the old setting, and later frames use the new setting and its new numbering.
- R9: On a drop the index output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Bank configuration write enable |
| cfg_bank_i | input | $clog2(NB) | Bank selected for the write |
| cfg_data_i | input | 4 | {fifo1, enable, list, wide} |
| frame_valid_i | input | 1 | Hit vector is valid for one frame |
| hit_i | input | NB*4 | Per-slot comparator hits, bit 4*b+s |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_dest_o | output | 2 | Destination code |
| res_index_o | output | IDX_W | Filter match index |

## Verification
The assertions rely on `frame_valid_i` being a single-cycle qualifier per frame. They also rely on the hit vector being meaningful only in that cycle, and on reset being held from time zero. The bench raises `frame_valid_i` for exactly one cycle per frame, or for consecutive cycles when it tests back-to-back frames. It changes inputs only on the falling clock edge and clears the hit vector between frames. Configuration writes are mostly issued with no frame in flight. The exception is one deliberate test in which a write and a frame fall in the same cycle, which checks that the frame uses the old setting.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;
  localparam int SLOTS  = 4;
  localparam int SLOT_W = 2;

  localparam logic [1:0] DEST_F0   = 2'b00;
  localparam logic [1:0] DEST_F1   = 2'b01;
  localparam logic [1:0] DEST_DROP = 2'b10;

  typedef struct packed {
    logic to_f1;
    logic active;
    logic list;
    logic wide;
  } bank_cfg_t;

  // filters held by a bank in its current shape
  function automatic logic [2:0] filt_count(input bank_cfg_t c);
    case ({c.wide, c.list})
      2'b10:   return 3'd1;
      2'b11:   return 3'd2;
      2'b00:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // 0 = 32-bit list (best) ... 3 = 16-bit mask (worst)
  function automatic logic [1:0] prio_class(input bank_cfg_t c);
    return {~c.wide, ~c.list};
  endfunction
endpackage

// File: rtl/flt_bank_eval.sv
module flt_bank_eval
  import can_flt_pkg::*;
(
  input  bank_cfg_t               cfg_i,
  input  logic [SLOTS-1:0]        hit_i,
  output logic                    hit_any_o,
  output logic [SLOT_W-1:0]       first_o
);
  logic [2:0]       cnt;
  logic [SLOTS-1:0] hit_m;

  always_comb begin
    cnt = filt_count(cfg_i);
    for (int j = 0; j < SLOTS; j++) begin
      hit_m[j] = hit_i[j] & cfg_i.active & (3'(j) < cnt);
    end
    first_o = '0;
    for (int j = SLOTS - 1; j >= 0; j--) begin
      if (hit_m[j]) first_o = SLOT_W'(j);
    end
    hit_any_o = |hit_m;
  end
endmodule

// File: rtl/flt_index_base.sv
module flt_index_base
  import can_flt_pkg::*;
#(
  parameter int NB    = 14,
  parameter int IDX_W = 8
) (
  input  bank_cfg_t          cfg_i  [NB],
  output logic [IDX_W-1:0]   base_o [NB]
);
  logic [IDX_W-1:0] run0, run1;

  always_comb begin
    run0 = '0;
    run1 = '0;
    for (int b = 0; b < NB; b++) begin
      if (cfg_i[b].to_f1) begin
        base_o[b] = run1;
        run1      = run1 + IDX_W'(filt_count(cfg_i[b]));
      end else begin
        base_o[b] = run0;
        run0      = run0 + IDX_W'(filt_count(cfg_i[b]));
      end
    end
  end
endmodule

// File: rtl/flt_fifo_pick.sv
module flt_fifo_pick
  import can_flt_pkg::*;
#(
  parameter int   NB       = 14,
  parameter int   IDX_W    = 8,
  parameter logic FIFO_SEL = 1'b0
) (
  input  bank_cfg_t            cfg_i     [NB],
  input  logic [NB-1:0]        hit_any_i,
  input  logic [SLOT_W-1:0]    first_i   [NB],
  input  logic [IDX_W-1:0]     base_i    [NB],
  output logic                 found_o,
  output logic [IDX_W-1:0]     idx_o
);
  logic [2:0] best;
  logic [2:0] cls;

  // descending scan with <= lets the lowest bank of the best class win
  always_comb begin
    best  = 3'd4;
    idx_o = '0;
    cls   = '0;
    for (int b = NB - 1; b >= 0; b--) begin
      cls = {1'b0, prio_class(cfg_i[b])};
      if ((cfg_i[b].to_f1 == FIFO_SEL) && hit_any_i[b] && (cls <= best)) begin
        best  = cls;
        idx_o = base_i[b] + IDX_W'(first_i[b]);
      end
    end
    found_o = (best != 3'd4);
  end
endmodule

// File: rtl/can_flt_resolver.sv
module can_flt_resolver
  import can_flt_pkg::*;
#(
  parameter int NB    = 14,
  parameter int IDX_W = 8,
  localparam int BANK_W = $clog2(NB),
  localparam int HIT_W  = NB * SLOTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we_i,
  input  logic [BANK_W-1:0] cfg_bank_i,
  input  logic [3:0]        cfg_data_i,
  input  logic              frame_valid_i,
  input  logic [HIT_W-1:0]  hit_i,
  output logic              res_valid_o,
  output logic [1:0]        res_dest_o,
  output logic [IDX_W-1:0]  res_index_o
);
  bank_cfg_t         cfg_q   [NB];
  logic [NB-1:0]     hit_any;
  logic [SLOT_W-1:0] first   [NB];
  logic [IDX_W-1:0]  base    [NB];
  logic [1:0]        found;
  logic [IDX_W-1:0]  pick_idx [2];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NB; b++) cfg_q[b] <= '0;
    end else if (cfg_we_i && (32'(cfg_bank_i) < NB)) begin
      cfg_q[cfg_bank_i] <= bank_cfg_t'(cfg_data_i);
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    flt_bank_eval u_eval (
      .cfg_i     (cfg_q[b]),
      .hit_i     (hit_i[b*SLOTS +: SLOTS]),
      .hit_any_o (hit_any[b]),
      .first_o   (first[b])
    );
  end

  flt_index_base #(.NB(NB), .IDX_W(IDX_W)) u_base (
    .cfg_i  (cfg_q),
    .base_o (base)
  );

  for (genvar f = 0; f < 2; f++) begin : g_fifo
    flt_fifo_pick #(.NB(NB), .IDX_W(IDX_W), .FIFO_SEL(f[0])) u_pick (
      .cfg_i     (cfg_q),
      .hit_any_i (hit_any),
      .first_i   (first),
      .base_i    (base),
      .found_o   (found[f]),
      .idx_o     (pick_idx[f])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_o <= 1'b0;
      res_dest_o  <= DEST_DROP;
      res_index_o <= '0;
    end else begin
      res_valid_o <= frame_valid_i;
      if (frame_valid_i) begin
        if (found[0]) begin
          res_dest_o  <= DEST_F0;
          res_index_o <= pick_idx[0];
        end else if (found[1]) begin
          res_dest_o  <= DEST_F1;
          res_index_o <= pick_idx[1];
        end else begin
          res_dest_o  <= DEST_DROP;
          res_index_o <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/can_flt_resolver_chk.sv
module can_flt_resolver_chk #(
  parameter int NB    = 14,
  parameter int IDX_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_valid_i,
  input logic [NB*4-1:0]   hit_i,
  input logic              res_valid_o,
  input logic [1:0]        res_dest_o,
  input logic [IDX_W-1:0]  res_index_o
);
  p_strobe_follows_r2: assert property (@(posedge clk) disable iff (rst)
    frame_valid_i |=> res_valid_o);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    !frame_valid_i |=> !res_valid_o);

  p_dest_code_r3: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> (res_dest_o != 2'b11));

  p_drop_index_r9: assert property (@(posedge clk) disable iff (rst)
    (res_valid_o && res_dest_o == 2'b10) |-> (res_index_o == '0));

  p_accept_needs_hit_r5: assert property (@(posedge clk) disable iff (rst)
    (res_valid_o && res_dest_o != 2'b10) |-> $past(|hit_i));

  p_index_range_r6: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> (32'(res_index_o) < NB * 4));
endmodule

bind can_flt_resolver can_flt_resolver_chk #(.NB(NB), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .frame_valid_i (frame_valid_i),
  .hit_i         (hit_i),
  .res_valid_o   (res_valid_o),
  .res_dest_o    (res_dest_o),
  .res_index_o   (res_index_o)
);

// File: tb/can_flt_resolver_tb_top.sv
`timescale 1ns/1ps
module can_flt_resolver_tb_top;
  localparam int NB     = 14;
  localparam int IDX_W  = 8;
  localparam int BANK_W = $clog2(NB);
  localparam int HIT_W  = NB * 4;
  localparam logic [HIT_W-1:0] H1 = 1;

  typedef struct packed {
    logic [HIT_W-1:0] hits;
    logic [1:0]       dest;
    logic [7:0]       idx;
    logic [3:0]       req;
  } vec_t;

  // bank b slot s is H1 << (4*b+s); setup below gives FIFO0: b0 idx0-3,
  // b2 4-5 (off), b3 6, b5 7-8; FIFO1: b1 0, b4 1-2, b6 3-4
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{H1 << 2,                  2'b00, 8'd2, 4'd6},  // R6 slot order
    '{(H1 << 0) | (H1 << 3),    2'b00, 8'd0, 4'd7},  // R7 lowest index
    '{(H1 << 12) | (H1 << 1),   2'b00, 8'd6, 4'd7},  // R7 32 beats 16
    '{(H1 << 21) | (H1 << 12),  2'b00, 8'd8, 4'd7},  // R7 list beats mask
    '{H1 << 4,                  2'b01, 8'd0, 4'd4},  // R4 FIFO1 only
    '{H1 << 17,                 2'b01, 8'd2, 4'd6},  // R6 FIFO1 numbering
    '{(H1 << 24) | (H1 << 16),  2'b01, 8'd3, 4'd7},  // R7 in FIFO1
    '{(H1 << 4) | (H1 << 0),    2'b00, 8'd0, 4'd3},  // R3 FIFO0 first
    '{H1 << 8,                  2'b10, 8'd0, 4'd5},  // R5 disabled bank
    '{H1 << 13,                 2'b10, 8'd0, 4'd5},  // R5 slot past count
    '{H1 << 5,                  2'b10, 8'd0, 4'd5},  // R5 slot past count
    '{'0,                       2'b10, 8'd0, 4'd4},  // R4 no hit, R9
    '{H1 << 19,                 2'b10, 8'd0, 4'd5},  // R5 16-bit mask slot3
    '{(H1 << 9) | (H1 << 20),   2'b00, 8'd7, 4'd6}   // R6 off bank counted
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [BANK_W-1:0] cfg_bank = '0;
  logic [3:0]        cfg_data = '0;
  logic              fv = 1'b0;
  logic [HIT_W-1:0]  hits = '0;
  logic              res_valid;
  logic [1:0]        res_dest;
  logic [IDX_W-1:0]  res_index;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  can_flt_resolver #(.NB(NB), .IDX_W(IDX_W)) dut_i (
    .clk           (clk),
    .rst           (rst),
    .cfg_we_i      (cfg_we),
    .cfg_bank_i    (cfg_bank),
    .cfg_data_i    (cfg_data),
    .frame_valid_i (fv),
    .hit_i         (hits),
    .res_valid_o   (res_valid),
    .res_dest_o    (res_dest),
    .res_index_o   (res_index)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input int bank, input logic [3:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = BANK_W'(bank); cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic frame(input logic [HIT_W-1:0] h, input logic [1:0] d,
                       input logic [7:0] ix, input string tag);
    @(negedge clk);
    fv = 1'b1; hits = h;
    @(negedge clk);
    fv = 1'b0; hits = '0;
    chk({tag, " valid"}, 32'(res_valid), 32'd1);
    chk({tag, " dest"},  32'(res_dest),  32'(d));
    chk({tag, " index"}, 32'(res_index), 32'(ix));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 reset valid", 32'(res_valid), 32'd0);
    chk("R1 reset dest",  32'(res_dest),  32'd2);
    chk("R1 reset index", 32'(res_index), 32'd0);
    frame('1, 2'b10, 8'd0, "R1 all banks off");
    @(negedge clk);
    chk("R2 no strobe without frame", 32'(res_valid), 32'd0);

    // R8 configuration
    wr_cfg(0, 4'b0110);
    wr_cfg(1, 4'b1101);
    wr_cfg(2, 4'b0011);
    wr_cfg(3, 4'b0101);
    wr_cfg(4, 4'b1100);
    wr_cfg(5, 4'b0111);
    wr_cfg(6, 4'b1111);

    for (int i = 0; i < NV; i++) begin
      frame(VECS[i].hits, VECS[i].dest, VECS[i].idx,
            $sformatf("R%0d vec%0d", VECS[i].req, i));
    end

    // R2 back-to-back frames
    @(negedge clk);
    fv = 1'b1; hits = H1 << 2;
    @(negedge clk);
    hits = H1 << 4;
    chk("R2 b2b first valid", 32'(res_valid), 32'd1);
    chk("R2 b2b first index", 32'(res_index), 32'd2);
    @(negedge clk);
    fv = 1'b0; hits = '0;
    chk("R2 b2b second valid", 32'(res_valid), 32'd1);
    chk("R2 b2b second dest",  32'(res_dest),  32'd1);
    @(negedge clk);
    chk("R2 strobe drops", 32'(res_valid), 32'd0);

    // R8 write and frame in the same cycle: old setting applies
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = BANK_W'(2); cfg_data = 4'b0111;
    fv = 1'b1; hits = H1 << 8;
    @(negedge clk);
    cfg_we = 1'b0; fv = 1'b0; hits = '0;
    chk("R8 same-cycle write old cfg", 32'(res_dest), 32'd2);
    frame(H1 << 8, 2'b00, 8'd4, "R8 new cfg applies");

    // R8/R6 moving bank0 to FIFO1 renumbers both FIFOs
    wr_cfg(0, 4'b1110);
    frame(H1 << 25, 2'b01, 8'd8, "R6 renumber FIFO1");
    frame(H1 << 20, 2'b00, 8'd3, "R6 renumber FIFO0");
    frame(H1 << 3,  2'b01, 8'd3, "R8 bank0 now FIFO1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule